// File: doc/BRIEF.md
# T1 Transmit Alarm and Loop-Code Inserter

This block sits on the transmit side of a T1 framer. It carries one line bit per clock and rewrites outgoing bits according to a set of alarm and maintenance requests. A T1 frame is 193 bits: one framing bit followed by 24 eight-bit channels. The framer marks the framing bit with `frame_start` and the first frame of each multiframe with `mframe_start`. The multiframe is 24 frames long in extended-superframe (ESF) mode and 12 frames long in superframe (D4) mode.

Four kinds of insertion are supported. Yellow alarm takes one of three forms: a 16-bit pattern on the ESF data-link bits, a forced zero in bit 2 of every channel in D4 mode, or a forced one in the S bit of the twelfth D4 frame. The other three override the whole line: all-ones, a repeating loop-up code and a repeating loop-down code. A framed/unframed select decides whether the framing bit is kept. An overhead-keep select passes the framing bit through even during unframed insertion.

The request inputs are sampled only on the framing bit, so a new setting starts at a frame boundary. The output is registered and lags the input stream by one clock.

Top module: `t1_alarm_inserter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout` is 0 after that edge. Otherwise `dout` shows the result for the bit presented on the previous clock.
- R2: With no request active (`all_ones_n` high, all other requests low), `dout` equals `din` delayed by one clock.
- R3: All request, mode and select inputs are captured on the cycle where `frame_start` is high, and that cycle already uses them. Values presented on other bits of the frame have no effect.
- R4: All-ones is active low. While it is active, every payload bit is 1. When framed is deselected and overhead-keep is low, the framing bit is also 1.
- R5: Loop-up sends 0,0,0,0,1 repeated. The pattern starts at its first 0 on the first advancing bit after the captured request rises.
- R6: Loop-down sends 0,0,1 repeated. The pattern starts at its first 0 on the first advancing bit after the captured request rises.
- R7: With framed selected, the loop generators advance only on payload bits (positions 1..192) and the framing bit passes `din`. With framed deselected, they advance on every bit, and the framing bit carries the code unless overhead-keep is set.
- R8: With overhead-keep set, the framing bit passes `din` during all-ones, loop-up or loop-down, even when unframed. An unframed generator still advances on that bit.
- R9: Priority is all-ones, then loop-up, then loop-down. Each loop generator keeps advancing while its own request is captured, even when a higher-priority code is masking it.
- R10: In ESF mode, the data-link bits are the framing bits of multiframe frames 0,2,4,...,22, counted from 0. With ESF yellow requested, they carry eight 1s then eight 0s, repeated and restarted when the request rises. If `japan_mode` is set, they carry all 1s instead. The other framing bits pass `din`.
- R11: In D4 mode with D4 yellow requested, the second bit of every channel (frame position p with (p-1) mod 8 = 1) is sent as 0.
- R12: In D4 mode with secondary yellow requested, the framing bit of frame 11 of the superframe (counted from 0) is sent as 1.
- R13: Yellow insertion of any form applies only while all-ones, loop-up and loop-down are all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Incoming serial line bit |
| frame_start | input | 1 | High on the framing bit of each frame |
| mframe_start | input | 1 | High with `frame_start` on the first frame of a multiframe |
| esf_mode | input | 1 | 1 = ESF, 0 = D4 |
| japan_mode | input | 1 | ESF yellow uses all ones on the data link |
| esf_yel_req | input | 1 | ESF yellow alarm request |
| d4_yel_req | input | 1 | D4 channel-bit yellow request |
| sec_yel_req | input | 1 | D4 secondary yellow (S bit) request |
| all_ones_n | input | 1 | Active-low transmit all-ones |
| loop_up_req | input | 1 | Loop-up code request |
| loop_down_req | input | 1 | Loop-down code request |
| framed_sel | input | 1 | 1 = framed insertion, 0 = unframed |
| overhead_keep | input | 1 | Pass framing bits during code insertion |
| dout | output | 1 | Outgoing serial line bit, one cycle behind `din` |

## Verification
The assertions assume that `frame_start` arrives exactly every 193 bits. They also assume that `mframe_start` is only raised together with `frame_start`, every 24 frames in ESF and every 12 in D4. Position-based properties such as the D4 S-bit and the data-link bits hold only under that framing. The bench builds its frame and multiframe markers from its own counters, so every segment of stimulus stays within this contract. Data bits are random. Control inputs may change in the middle of a frame or toggle randomly there, but at each framing bit they hold a chosen setting.

// File: rtl/t1_ins_pkg.sv
// Shared types for the T1 transmit alarm inserter.
// Assumes: one field per control input, all captured together at a frame boundary.
package t1_ins_pkg;

    typedef struct packed {
        logic esf;         // 1 = ESF, 0 = D4
        logic japan;       // ESF yellow as all ones
        logic yel_esf;     // ESF data-link yellow
        logic yel_d4;      // D4 channel-bit yellow
        logic yel_sec;     // D4 secondary yellow on the S bit
        logic all_ones_n;  // active-low all-ones
        logic loop_up;     // loop-up code
        logic loop_down;   // loop-down code
        logic framed;      // framed insertion
        logic oh_keep;     // keep framing bits during code insertion
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{esf: 1'b0, japan: 1'b0, yel_esf: 1'b0,
                                    yel_d4: 1'b0, yel_sec: 1'b0, all_ones_n: 1'b1,
                                    loop_up: 1'b0, loop_down: 1'b0, framed: 1'b0,
                                    oh_keep: 1'b0};

endpackage

// File: rtl/t1_frame_pos.sv
// Frame position tracker.
// Tracks the bit index within a frame and the frame index within a multiframe.
// Decodes the positions the override logic needs: framing bit, data-link
// frame, last superframe frame, and the yellow bit of each channel.
// Assumes: frame_start recurs every FRAME_BITS bits, mframe_start only with
// frame_start, and CH_BITS is a power of two.
module t1_frame_pos #(
    parameter int FRAME_BITS = 193,
    parameter int CH_BITS    = 8,
    parameter int MF_FRAMES  = 24,
    parameter int SF_FRAMES  = 12,
    parameter int YEL_BIT    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic mframe_start,
    output logic bit_zero,
    output logic dl_frame,
    output logic sf_last,
    output logic chan_yel_bit
);
    localparam int BW  = $clog2(FRAME_BITS);
    localparam int FW  = $clog2(MF_FRAMES);
    localparam int CBW = $clog2(CH_BITS);

    logic [BW-1:0] bit_q, bit_cur, bit_off;
    logic [FW-1:0] frm_q, frm_cur;

    // Current bit and frame position, derived from the markers and the last position.
    always_comb begin
        if (frame_start) begin
            bit_cur = '0;
        end else if (bit_q == BW'(FRAME_BITS - 1)) begin
            bit_cur = '0;
        end else begin
            bit_cur = bit_q + 1'b1;
        end
        if (frame_start && mframe_start) begin
            frm_cur = '0;
        end else if (frame_start) begin
            frm_cur = (frm_q == FW'(MF_FRAMES - 1)) ? '0 : frm_q + 1'b1;
        end else begin
            frm_cur = frm_q;
        end
    end

    // Decodes the positions the override logic uses.
    always_comb begin
        bit_off      = bit_cur - 1'b1;
        bit_zero     = (bit_cur == '0);
        dl_frame     = ~frm_cur[0];
        sf_last      = (frm_cur == FW'(SF_FRAMES - 1));
        chan_yel_bit = !bit_zero && (bit_off[CBW-1:0] == CBW'(YEL_BIT - 1));
    end

    // Stores the current position for the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= BW'(FRAME_BITS - 1);
            frm_q <= FW'(MF_FRAMES - 1);
        end else begin
            bit_q <= bit_cur;
            frm_q <= frm_cur;
        end
    end

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bit_q < BW'(FRAME_BITS)) && (frm_q < FW'(MF_FRAMES))); // R3

endmodule

// File: rtl/t1_pat_gen.sv
// Repeating pattern generator.
// Emits a 1 while its phase lies in [HI_FIRST, HI_LAST], otherwise 0, over a
// cycle of PERIOD steps. The phase restarts at 0 on the cycle the request
// rises, moves forward on cycles where req and adv are both high, and holds
// otherwise.
// Assumes: req changes only at frame boundaries.
module t1_pat_gen #(
    parameter int PERIOD   = 5,
    parameter int HI_FIRST = 4,
    parameter int HI_LAST  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic adv,
    output logic pat_bit
);
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] ph_q, ph_cur, ph_inc;
    logic          req_q;

    // Selects the phase for this bit and the phase after it.
    always_comb begin
        ph_cur  = (req && !req_q) ? '0 : ph_q;
        ph_inc  = (ph_cur == PW'(PERIOD - 1)) ? '0 : ph_cur + 1'b1;
        pat_bit = (int'(ph_cur) >= HI_FIRST) && (int'(ph_cur) <= HI_LAST);
    end

    // Phase and request history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= req;
            ph_q  <= (req && adv) ? ph_inc : ph_cur;
        end
    end

    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) && !adv |=> ph_q == '0); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(ph_q)); // R9

endmodule

// File: rtl/t1_override_mux.sv
// Per-bit override selection.
// Chooses between the line bit, the code insertions (all-ones, loop-up,
// loop-down, in that priority) and the yellow alarm forms for the current
// position.
// Assumes: ctl holds the control captured for the current frame.
module t1_override_mux
    import t1_ins_pkg::*;
(
    input  ctrl_t ctl,
    input  logic  din,
    input  logic  bit_zero,
    input  logic  dl_frame,
    input  logic  sf_last,
    input  logic  chan_yel_bit,
    input  logic  lu_bit,
    input  logic  ld_bit,
    input  logic  ye_bit,
    output logic  code_act,
    output logic  bit_o
);
    logic ao_act, code_bit, keep_fb;

    // Resolves the priority among the codes and the framing-bit policy.
    always_comb begin
        ao_act   = !ctl.all_ones_n;
        code_act = ao_act || ctl.loop_up || ctl.loop_down;
        code_bit = ao_act ? 1'b1 : (ctl.loop_up ? lu_bit : ld_bit);
        keep_fb  = ctl.framed || ctl.oh_keep;
    end

    // Builds the outgoing bit.
    always_comb begin
        if (code_act) begin
            bit_o = (bit_zero && keep_fb) ? din : code_bit;
        end else if (ctl.esf) begin
            if (ctl.yel_esf && bit_zero && dl_frame) begin
                bit_o = ctl.japan ? 1'b1 : ye_bit;
            end else begin
                bit_o = din;
            end
        end else if (ctl.yel_sec && bit_zero && sf_last) begin
            bit_o = 1'b1;
        end else if (ctl.yel_d4 && chan_yel_bit) begin
            bit_o = 1'b0;
        end else begin
            bit_o = din;
        end
    end

endmodule

// File: rtl/t1_alarm_inserter.sv
// T1 transmit alarm and loop-code inserter (top).
// Captures the control inputs on each framing bit. Runs the loop-up,
// loop-down and ESF yellow pattern generators, and rewrites the serial
// stream one bit per clock with one register of latency.
// Assumes: one line bit per clock, with well-formed frame and multiframe markers.
module t1_alarm_inserter
    import t1_ins_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int CH_BITS    = 8,
    parameter int MF_FRAMES  = 24,
    parameter int SF_FRAMES  = 12,
    parameter int YEL_BIT    = 2,
    parameter int YEL_RUN    = 8,
    parameter int LU_LEN     = 5,
    parameter int LD_LEN     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic frame_start,
    input  logic mframe_start,
    input  logic esf_mode,
    input  logic japan_mode,
    input  logic esf_yel_req,
    input  logic d4_yel_req,
    input  logic sec_yel_req,
    input  logic all_ones_n,
    input  logic loop_up_req,
    input  logic loop_down_req,
    input  logic framed_sel,
    input  logic overhead_keep,
    output logic dout
);
    ctrl_t ctrl_in, ctrl_q, ctrl_eff;
    logic  bit_zero, dl_frame, sf_last, chan_yel_bit;
    logic  code_adv, ye_req, ye_adv;
    logic  lu_bit, ld_bit, ye_bit, code_act, bit_next;

    // Packs the control inputs and picks the setting in force for this bit.
    always_comb begin
        ctrl_in = '{esf: esf_mode, japan: japan_mode, yel_esf: esf_yel_req,
                    yel_d4: d4_yel_req, yel_sec: sec_yel_req, all_ones_n: all_ones_n,
                    loop_up: loop_up_req, loop_down: loop_down_req,
                    framed: framed_sel, oh_keep: overhead_keep};
        ctrl_eff = frame_start ? ctrl_in : ctrl_q;
    end

    // Holds the control captured at the last framing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_IDLE;
        end else if (frame_start) begin
            ctrl_q <= ctrl_in;
        end
    end

    t1_frame_pos #(
        .FRAME_BITS (FRAME_BITS),
        .CH_BITS    (CH_BITS),
        .MF_FRAMES  (MF_FRAMES),
        .SF_FRAMES  (SF_FRAMES),
        .YEL_BIT    (YEL_BIT)
    ) u_pos (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .mframe_start (mframe_start),
        .bit_zero     (bit_zero),
        .dl_frame     (dl_frame),
        .sf_last      (sf_last),
        .chan_yel_bit (chan_yel_bit)
    );

    // Advance rules for the code and data-link generators.
    always_comb begin
        code_adv = ctrl_eff.framed ? !bit_zero : 1'b1;
        ye_req   = ctrl_eff.yel_esf && ctrl_eff.esf;
        ye_adv   = bit_zero && dl_frame && ctrl_eff.esf;
    end

    t1_pat_gen #(.PERIOD(LU_LEN), .HI_FIRST(LU_LEN - 1), .HI_LAST(LU_LEN - 1)) u_lu (
        .clk (clk), .rst_n (rst_n), .req (ctrl_eff.loop_up), .adv (code_adv), .pat_bit (lu_bit)
    );

    t1_pat_gen #(.PERIOD(LD_LEN), .HI_FIRST(LD_LEN - 1), .HI_LAST(LD_LEN - 1)) u_ld (
        .clk (clk), .rst_n (rst_n), .req (ctrl_eff.loop_down), .adv (code_adv), .pat_bit (ld_bit)
    );

    t1_pat_gen #(.PERIOD(2 * YEL_RUN), .HI_FIRST(0), .HI_LAST(YEL_RUN - 1)) u_ye (
        .clk (clk), .rst_n (rst_n), .req (ye_req), .adv (ye_adv), .pat_bit (ye_bit)
    );

    t1_override_mux u_mux (
        .ctl          (ctrl_eff),
        .din          (din),
        .bit_zero     (bit_zero),
        .dl_frame     (dl_frame),
        .sf_last      (sf_last),
        .chan_yel_bit (chan_yel_bit),
        .lu_bit       (lu_bit),
        .ld_bit       (ld_bit),
        .ye_bit       (ye_bit),
        .code_act     (code_act),
        .bit_o        (bit_next)
    );

    // Output register: one clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else begin
            dout <= bit_next;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !dout); // R1
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ctrl_q)); // R3
    AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_eff == CTRL_IDLE |=> dout == $past(din)); // R2
    AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_eff.all_ones_n && !bit_zero |=> dout); // R4
    AST_D4_YEL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_eff.esf && ctrl_eff.yel_d4 && !code_act && chan_yel_bit |=> !dout); // R11
    AST_SEC_YEL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_eff.esf && ctrl_eff.yel_sec && !code_act && bit_zero && sf_last |=> dout); // R12

endmodule

// File: tb/t1_alarm_inserter_bench.sv
module t1_alarm_inserter_bench;
    import t1_ins_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic din = 1'b0, frame_start = 1'b0, mframe_start = 1'b0;
    ctrl_t drv = CTRL_IDLE;
    logic dout;

    t1_alarm_inserter u_t1_alarm_inserter (
        .clk (clk), .rst_n (rst_n), .din (din),
        .frame_start (frame_start), .mframe_start (mframe_start),
        .esf_mode (drv.esf), .japan_mode (drv.japan), .esf_yel_req (drv.yel_esf),
        .d4_yel_req (drv.yel_d4), .sec_yel_req (drv.yel_sec), .all_ones_n (drv.all_ones_n),
        .loop_up_req (drv.loop_up), .loop_down_req (drv.loop_down),
        .framed_sel (drv.framed), .overhead_keep (drv.oh_keep), .dout (dout)
    );

    int n_vec = 0, n_bad = 0;

    // reference model state
    int m_bit = 192, m_frm = 23;
    ctrl_t m_ctl = CTRL_IDLE;
    int lu_ph = 0, ld_ph = 0, ye_ph = 0;
    bit lu_prev = 0, ld_prev = 0, ye_prev = 0;
    ctrl_t cur_cfg = CTRL_IDLE;

    logic  exp_q = 1'b0;
    string exp_tag = "";
    bit    pend = 0;

    function automatic ctrl_t mk(bit esf, bit jp, bit ye, bit yd, bit ys, bit aon,
                                 bit lu, bit ld, bit fr, bit oh);
        ctrl_t c;
        c = '{esf: esf, japan: jp, yel_esf: ye, yel_d4: yd, yel_sec: ys,
              all_ones_n: aon, loop_up: lu, loop_down: ld, framed: fr, oh_keep: oh};
        return c;
    endfunction

    // computes the expected output bit from the requirements
    task automatic model(input logic d, input bit fs, input bit mfs, input ctrl_t cin,
                         output logic e, output string tag);
        bit ao, lu, ld, ye, adv, code, lub, ldb, yeb, fdl;
        if (fs) begin
            m_bit = 0;
            m_frm = mfs ? 0 : (m_frm + 1) % 24;
            m_ctl = cin;
        end else begin
            m_bit = (m_bit + 1) % 193;
        end
        ao   = !m_ctl.all_ones_n;
        lu   = m_ctl.loop_up;
        ld   = m_ctl.loop_down;
        ye   = m_ctl.yel_esf && m_ctl.esf;
        adv  = m_ctl.framed ? (m_bit != 0) : 1'b1;
        fdl  = m_ctl.esf && m_bit == 0 && (m_frm % 2 == 0);
        code = ao || lu || ld;
        if (lu && !lu_prev) lu_ph = 0;
        lub = (lu_ph == 4);
        if (lu && adv) lu_ph = (lu_ph + 1) % 5;
        lu_prev = lu;
        if (ld && !ld_prev) ld_ph = 0;
        ldb = (ld_ph == 2);
        if (ld && adv) ld_ph = (ld_ph + 1) % 3;
        ld_prev = ld;
        if (ye && !ye_prev) ye_ph = 0;
        yeb = (ye_ph < 8);
        if (ye && fdl) ye_ph = (ye_ph + 1) % 16;
        ye_prev = ye;
        if (code) begin
            if (m_bit == 0 && (m_ctl.framed || m_ctl.oh_keep)) begin
                e = d;
                tag = m_ctl.framed ? "R7" : "R8";
            end else begin
                e   = ao ? 1'b1 : (lu ? lub : ldb);
                tag = ao ? "R4" : (lu ? "R5" : "R6");
                if (m_bit == 0) tag = "R7";
                if ((ao && (lu || ld)) || (lu && ld)) tag = "R9";
            end
            if (m_ctl.yel_esf || m_ctl.yel_d4 || m_ctl.yel_sec) tag = "R13";
        end else if (m_ctl.esf) begin
            if (m_ctl.yel_esf && fdl) begin
                e = m_ctl.japan ? 1'b1 : yeb;
                tag = "R10";
            end else begin
                e = d;
                tag = "R2";
            end
        end else if (m_ctl.yel_sec && m_bit == 0 && m_frm == 11) begin
            e = 1'b1;
            tag = "R12";
        end else if (m_ctl.yel_d4 && m_bit != 0 && ((m_bit - 1) % 8 == 1)) begin
            e = 1'b0;
            tag = "R11";
        end else begin
            e = d;
            tag = "R2";
        end
        if (!fs && cin != m_ctl) tag = "R3";
    endtask

    task automatic check_pending();
        if (pend) begin
            n_vec++;
            if (dout !== exp_q) begin
                n_bad++;
                $display("FAIL %s: dout=%0b expected %0b (bit %0d frame %0d)",
                         exp_tag, dout, exp_q, m_bit, m_frm);
            end
        end
    endtask

    task automatic drive_bit(input logic d, input bit fs, input bit mfs, input ctrl_t c);
        logic  e;
        string t;
        @(negedge clk);
        check_pending();
        rst_n        = 1'b1;
        din          = d;
        frame_start  = fs;
        mframe_start = mfs;
        drv          = c;
        model(d, fs, mfs, c, e, t);
        exp_q   = e;
        exp_tag = t;
        pend    = 1;
    endtask

    task automatic run_seg(input ctrl_t cfg, input int frames, input int sf_len, input bit glitch);
        int sw;
        sw = 1 + $urandom_range(191);
        for (int f = 0; f < frames; f++) begin
            for (int b = 0; b < 193; b++) begin
                ctrl_t c;
                if (f == 0 && b == sw) cur_cfg = cfg;
                c = cur_cfg;
                if (glitch && b != 0 && $urandom_range(3) == 0) c = ctrl_t'($urandom);
                drive_bit(1'($urandom_range(1)), b == 0, b == 0 && (f % sf_len) == 0, c);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1: watchdog expired, actual still running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1d5e7);
        // R1: output held low during reset
        repeat (3) begin
            @(negedge clk);
            din = 1'b1;
            n_vec++;
            if (dout !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: dout=%0b expected 0 in reset", dout);
            end
        end
        // directed: pass-through (R2), ESF yellow (R10), Japan (R10)
        run_seg(mk(1,0,0,0,0,1,0,0,1,0), 48, 24, 1);
        run_seg(mk(1,0,1,0,0,1,0,0,1,0), 48, 24, 1);
        run_seg(mk(1,1,1,0,0,1,0,0,1,0), 48, 24, 0);
        // D4 yellow and secondary yellow (R11, R12)
        run_seg(mk(0,0,0,1,1,1,0,0,1,0), 24, 12, 1);
        // all-ones framed / unframed (R4, R7)
        run_seg(mk(0,0,0,0,0,0,0,0,1,0), 24, 12, 0);
        run_seg(mk(0,0,0,0,0,0,0,0,0,0), 24, 12, 1);
        // loop-up framed, unframed with overhead keep (R5, R7, R8)
        run_seg(mk(1,0,0,0,0,1,1,0,1,0), 48, 24, 0);
        run_seg(mk(1,0,0,0,0,1,1,0,0,1), 48, 24, 1);
        // loop-down unframed (R6)
        run_seg(mk(0,0,0,0,0,1,0,1,0,0), 24, 12, 0);
        // priority with yellow masked (R9, R13)
        run_seg(mk(1,0,1,0,0,0,1,1,1,0), 24, 24, 0);
        run_seg(mk(1,0,1,0,0,1,1,1,1,0), 24, 24, 0);
        run_seg(mk(1,0,1,0,0,1,0,1,1,0), 24, 24, 0);
        // random settings in both modes
        for (int k = 0; k < 4; k++) begin
            ctrl_t r;
            r = ctrl_t'($urandom);
            run_seg(r, r.esf ? 24 : 12, r.esf ? 24 : 12, 1);
        end
        @(negedge clk);
        check_pending();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule